// File: doc/BRIEF.md
# Cycle-Steal DMA and Interrupt Entry Sequencer

This block runs beside a small processor's instruction sequencer and acts in the gap between one instruction and the next. When the processor signals the end of an execute cycle, the block looks at the pending requests. A DMA request takes exactly one machine cycle. In that cycle the transfer address comes from register zero of the register file, which the block holds. That register advances by one after every byte. Without a DMA request, an enabled interrupt makes the block enter the handler. It does this by packing the data-pointer and program-counter designators into one saved byte and pointing the program counter at register one.

Two interrupt sources are supported: an external request line and the underflow of an 8-bit down-counter. The counter reloads from a holding register. A latch records each counter underflow, and the underflow can also toggle the output flag Q. A master enable gates every interrupt. Each source also has its own enable. Instruction decode and memory timing are handled by the surrounding processor.

Top module: `dma_int_seq`

## Requirements
- R1: Suppose `execDone` is high in the normal state while `dmaInReq` or `dmaOutReq` is high. Then `stealCycle` is 1 in the following cycle only, and the block returns to the normal state after it. There is at most one stolen cycle per `execDone`.
- R2: In a DMA-in stolen cycle, `memWrite` = 1, `memAddr` = R0 and `memWrData` = `dmaInData`. If both request kinds are present, the cycle is a DMA-in cycle.
- R3: In a DMA-out stolen cycle, `dmaOutValid` = 1, `memWrite` = 0, `memAddr` = R0 and `dmaOutData` = `memRdData`.
- R4: `memAddr` always shows R0. R0 resets to 0. It increments by one, with 16-bit wrap, at the end of every stolen cycle. `r0Load` loads `r0LoadVal` and takes priority over the increment.
- R5: Interrupt entry happens when `execDone` is high, no DMA request is present, `mie` = 1, and either `extIntEn & extIntReq` or `cntIntEn & cil` holds. In the next cycle `intAck` = 1 for one cycle. `tReg` then equals {`curX`, `curP`} as sampled at the `execDone` edge, with X in bits 7:4 and P in bits 3:0.
- R6: Interrupt entry clears `mie`. Otherwise `mieSet` sets it and `mieClr` clears it, with set winning. While `mie` = 0, no interrupt entry occurs.
- R7: `chWrite` loads the holding register and `cntLoad` copies the holding register into `cnt`. Otherwise `cntTick` decrements `cnt`. A tick at `cnt` = 0 is an underflow, and it reloads `cnt` from the holding register.
- R8: An underflow sets `cil`. `cil` then stays set until `cilClear` is pulsed. When an underflow and `cilClear` fall in the same cycle, `cil` ends set.
- R9: `qWrite` sets `q` to `qValue`. Without `qWrite`, an underflow toggles `q` when `qFromCnt` = 1.
- R10: `pcSel` is 0 in a stolen cycle and 1 in the `intAck` cycle. In every other cycle it equals `curP`.
- R11: When a DMA request and an enabled interrupt are both present at `execDone`, the DMA cycle is taken. The interrupt waits for a later `execDone` with no DMA request.
- R12: After reset, `stealCycle`, `memWrite`, `dmaOutValid`, `intAck`, `mie`, `cil`, `q`, `cnt`, `tReg` and `memAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| execDone | input | 1 | Last cycle of an execute cycle |
| dmaInReq | input | 1 | Device-to-memory request |
| dmaOutReq | input | 1 | Memory-to-device request |
| dmaInData | input | 8 | Byte from the device |
| memRdData | input | 8 | Byte read from memory |
| extIntReq | input | 1 | External interrupt line |
| extIntEn | input | 1 | External interrupt enable |
| cntIntEn | input | 1 | Counter interrupt enable |
| mieSet | input | 1 | Set master enable |
| mieClr | input | 1 | Clear master enable |
| curX | input | 4 | Current data-pointer designator |
| curP | input | 4 | Current program-counter designator |
| r0Load | input | 1 | Load R0 |
| r0LoadVal | input | 16 | Value for R0 |
| chWrite | input | 1 | Write the holding register |
| chData | input | 8 | Holding register value |
| cntLoad | input | 1 | Copy the holding register into the counter |
| cntTick | input | 1 | Decrement the counter |
| cilClear | input | 1 | Clear the counter interrupt latch |
| qWrite | input | 1 | Write Q |
| qValue | input | 1 | Value for Q |
| qFromCnt | input | 1 | Let underflow toggle Q |
| stealCycle | output | 1 | Stolen DMA cycle in progress |
| memAddr | output | 16 | R0, the DMA address |
| memWrite | output | 1 | Memory write strobe (DMA-in) |
| memWrData | output | 8 | Byte to write to memory |
| dmaOutValid | output | 1 | DMA-out byte valid |
| dmaOutData | output | 8 | Byte to the device |
| intAck | output | 1 | Interrupt entry cycle |
| pcSel | output | 4 | Register acting as program counter |
| tReg | output | 8 | Saved {X, P} |
| mie | output | 1 | Master interrupt enable |
| cil | output | 1 | Counter interrupt latch |
| cnt | output | 8 | Counter value |
| q | output | 1 | Q flag |

## Verification
A DMA request and an enabled interrupt can be present at the same `execDone`. The bench forces this case directly: it raises a DMA request together with an external interrupt while `mie` is set. It then checks that the next cycle is a stolen cycle and not `intAck`, and that the interrupt is entered only after a later `execDone` with no request. A second collision is an underflow in the same cycle as `cilClear`. Random stimulus with a fixed seed produces both collisions many more times. A bench model compares every output on every cycle.

// File: rtl/dma_int_seq_pkg.sv
package dma_int_seq_pkg;
  typedef enum logic [1:0] {
    ST_NORM    = 2'd0,
    ST_DMA_IN  = 2'd1,
    ST_DMA_OUT = 2'd2,
    ST_INT     = 2'd3
  } seqState_t;

  typedef struct packed {
    logic incR0;
    logic intEnter;
  } seqStrobe_t;
endpackage

// File: rtl/dma_int_seq_ctrl.sv
module dma_int_seq_ctrl
  import dma_int_seq_pkg::*;
#(
  parameter int DES_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             execDone,
  input  logic             dmaInReq,
  input  logic             dmaOutReq,
  input  logic             extIntReq,
  input  logic             extIntEn,
  input  logic             cntIntEn,
  input  logic             mie,
  input  logic             cil,
  input  logic [DES_W-1:0] curP,
  output seqStrobe_t       str,
  output logic             stealCycle,
  output logic             memWrite,
  output logic             dmaOutValid,
  output logic             intAck,
  output logic [DES_W-1:0] pcSel
);
  seqState_t state, nextState;
  logic intReq;

  always_comb begin
    intReq = mie & ((extIntEn & extIntReq) | (cntIntEn & cil));
    nextState = ST_NORM;
    str = '0;
    if (state == ST_NORM && execDone) begin
      if (dmaInReq)       nextState = ST_DMA_IN;
      else if (dmaOutReq) nextState = ST_DMA_OUT;
      else if (intReq) begin
        nextState = ST_INT;
        str.intEnter = 1'b1;
      end
    end
    str.incR0 = (state == ST_DMA_IN) || (state == ST_DMA_OUT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_NORM;
    else       state <= nextState;
  end

  assign stealCycle  = (state == ST_DMA_IN) || (state == ST_DMA_OUT);
  assign memWrite    = (state == ST_DMA_IN);
  assign dmaOutValid = (state == ST_DMA_OUT);
  assign intAck      = (state == ST_INT);
  assign pcSel       = stealCycle ? '0 : (intAck ? DES_W'(1) : curP);

  // R1: a stolen cycle is never followed directly by another one
  assert_single_steal_R1: assert property (@(posedge clk) disable iff (!rstN)
    stealCycle |=> !stealCycle);
  // R11: a DMA request at execDone in the normal state always wins the next cycle
  assert_dma_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    (execDone && !stealCycle && !intAck && (dmaInReq || dmaOutReq)) |=> (stealCycle && !intAck));
  // R2: DMA-in takes precedence when both kinds are requested
  assert_in_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    (execDone && !stealCycle && !intAck && dmaInReq) |=> memWrite);
  // R6: interrupt entry is impossible while the master enable is low
  assert_no_entry_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    !mie |=> !intAck);
endmodule

// File: rtl/dma_int_seq_dp.sv
module dma_int_seq_dp
  import dma_int_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DES_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         str,
  input  logic [DES_W-1:0]   curX,
  input  logic [DES_W-1:0]   curP,
  input  logic               mieSet,
  input  logic               mieClr,
  input  logic               r0Load,
  input  logic [ADDR_W-1:0]  r0LoadVal,
  input  logic               chWrite,
  input  logic [CNT_W-1:0]   chData,
  input  logic               cntLoad,
  input  logic               cntTick,
  input  logic               cilClear,
  input  logic               qWrite,
  input  logic               qValue,
  input  logic               qFromCnt,
  output logic [ADDR_W-1:0]  r0,
  output logic [2*DES_W-1:0] tReg,
  output logic               mie,
  output logic               cil,
  output logic [CNT_W-1:0]   cnt,
  output logic               q
);
  logic [CNT_W-1:0] chReg;
  logic underflow;

  assign underflow = cntTick && !cntLoad && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r0 <= '0; tReg <= '0; mie <= 1'b0; cil <= 1'b0;
      cnt <= '0; chReg <= '0; q <= 1'b0;
    end else begin
      if (r0Load)         r0 <= r0LoadVal;
      else if (str.incR0) r0 <= r0 + 1'b1;
      if (str.intEnter) tReg <= {curX, curP};
      if (str.intEnter)  mie <= 1'b0;
      else if (mieSet)   mie <= 1'b1;
      else if (mieClr)   mie <= 1'b0;
      if (chWrite) chReg <= chData;
      if (cntLoad)      cnt <= chReg;
      else if (cntTick) cnt <= (cnt == '0) ? chReg : cnt - 1'b1;
      if (underflow)     cil <= 1'b1;
      else if (cilClear) cil <= 1'b0;
      if (qWrite)                      q <= qValue;
      else if (underflow && qFromCnt) q <= ~q;
    end
  end

  // R4: each stolen cycle advances R0 by one
  assert_r0_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (str.incR0 && !r0Load) |=> (r0 == $past(r0) + 1'b1));
  // R5: designators captured into T on entry
  assert_t_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.intEnter |=> (tReg == {$past(curX), $past(curP)}));
  // R6: entry leaves the master enable low
  assert_mie_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    str.intEnter |=> !mie);
  // R8: an underflow always leaves the latch set
  assert_cil_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> cil);
  // R8: the latch only falls when cleared
  assert_cil_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cil && !cilClear) |=> cil);
  // R7: an underflow reloads from the holding register
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !chWrite) |=> (cnt == chReg));
endmodule

// File: rtl/dma_int_seq.sv
module dma_int_seq
  import dma_int_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DES_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execDone,
  input  logic               dmaInReq,
  input  logic               dmaOutReq,
  input  logic [DATA_W-1:0]  dmaInData,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic               extIntReq,
  input  logic               extIntEn,
  input  logic               cntIntEn,
  input  logic               mieSet,
  input  logic               mieClr,
  input  logic [DES_W-1:0]   curX,
  input  logic [DES_W-1:0]   curP,
  input  logic               r0Load,
  input  logic [ADDR_W-1:0]  r0LoadVal,
  input  logic               chWrite,
  input  logic [CNT_W-1:0]   chData,
  input  logic               cntLoad,
  input  logic               cntTick,
  input  logic               cilClear,
  input  logic               qWrite,
  input  logic               qValue,
  input  logic               qFromCnt,
  output logic               stealCycle,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memWrite,
  output logic [DATA_W-1:0]  memWrData,
  output logic               dmaOutValid,
  output logic [DATA_W-1:0]  dmaOutData,
  output logic               intAck,
  output logic [DES_W-1:0]   pcSel,
  output logic [2*DES_W-1:0] tReg,
  output logic               mie,
  output logic               cil,
  output logic [CNT_W-1:0]   cnt,
  output logic               q
);
  seqStrobe_t str;

  dma_int_seq_ctrl #(.DES_W(DES_W)) uCtrl (
    .clk(clk), .rstN(rstN), .execDone(execDone), .dmaInReq(dmaInReq),
    .dmaOutReq(dmaOutReq), .extIntReq(extIntReq), .extIntEn(extIntEn),
    .cntIntEn(cntIntEn), .mie(mie), .cil(cil), .curP(curP), .str(str),
    .stealCycle(stealCycle), .memWrite(memWrite), .dmaOutValid(dmaOutValid),
    .intAck(intAck), .pcSel(pcSel)
  );

  dma_int_seq_dp #(.ADDR_W(ADDR_W), .DES_W(DES_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .curX(curX), .curP(curP),
    .mieSet(mieSet), .mieClr(mieClr), .r0Load(r0Load), .r0LoadVal(r0LoadVal),
    .chWrite(chWrite), .chData(chData), .cntLoad(cntLoad), .cntTick(cntTick),
    .cilClear(cilClear), .qWrite(qWrite), .qValue(qValue), .qFromCnt(qFromCnt),
    .r0(memAddr), .tReg(tReg), .mie(mie), .cil(cil), .cnt(cnt), .q(q)
  );

  assign memWrData  = dmaInData;
  assign dmaOutData = memRdData;
endmodule

// File: tb/sim_dma_int_seq.sv
module sim_dma_int_seq;
  logic clk = 1'b0, rstN = 1'b0;
  logic execDone = 0, dmaInReq = 0, dmaOutReq = 0, extIntReq = 0, extIntEn = 0;
  logic cntIntEn = 0, mieSet = 0, mieClr = 0, r0Load = 0, chWrite = 0;
  logic cntLoad = 0, cntTick = 0, cilClear = 0, qWrite = 0, qValue = 0, qFromCnt = 0;
  logic [7:0] dmaInData = 0, memRdData = 0, chData = 0;
  logic [3:0] curX = 0, curP = 0;
  logic [15:0] r0LoadVal = 0;
  logic stealCycle, memWrite, dmaOutValid, intAck, mie, cil, q;
  logic [15:0] memAddr;
  logic [7:0] memWrData, dmaOutData, tReg, cnt;
  logic [3:0] pcSel;

  int errors = 0, checks = 0;
  // model state: 0 normal, 1 DMA-in, 2 DMA-out, 3 interrupt entry
  int mState = 0;
  logic [15:0] mR0 = 0;
  logic [7:0] mT = 0, mCnt = 0, mCh = 0;
  logic mMie = 0, mCil = 0, mQ = 0;

  always #5 clk = ~clk;

  dma_int_seq u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic modelIntReq();
    return mMie & ((extIntEn & extIntReq) | (cntIntEn & mCil));
  endfunction

  task automatic checkOutputs();
    logic st = (mState == 1 || mState == 2);
    check("R1 stealCycle", 32'(stealCycle), 32'(st));
    check("R2 memWrite", 32'(memWrite), 32'(mState == 1));
    if (mState == 1) check("R2 memWrData", 32'(memWrData), 32'(dmaInData));
    check("R3 dmaOutValid", 32'(dmaOutValid), 32'(mState == 2));
    if (mState == 2) check("R3 dmaOutData", 32'(dmaOutData), 32'(memRdData));
    check("R4 memAddr", 32'(memAddr), 32'(mR0));
    check("R5 intAck", 32'(intAck), 32'(mState == 3));
    check("R5 tReg", 32'(tReg), 32'(mT));
    check("R6 mie", 32'(mie), 32'(mMie));
    check("R7 cnt", 32'(cnt), 32'(mCnt));
    check("R8 cil", 32'(cil), 32'(mCil));
    check("R9 q", 32'(q), 32'(mQ));
    check("R10 pcSel", 32'(pcSel), st ? 32'd0 : (mState == 3 ? 32'd1 : 32'(curP)));
  endtask

  // inputs are already driven; check, clock once, advance the model
  task automatic cycle();
    logic under;
    int nxt;
    #1 checkOutputs();
    @(posedge clk);
    under = cntTick && !cntLoad && (mCnt == 0);
    nxt = 0;
    if (mState == 0 && execDone) begin
      if (dmaInReq) nxt = 1;
      else if (dmaOutReq) nxt = 2;
      else if (modelIntReq()) begin
        nxt = 3; mT = {curX, curP};
      end
    end
    if (r0Load) mR0 = r0LoadVal;
    else if (mState == 1 || mState == 2) mR0 = mR0 + 16'd1;
    if (nxt == 3) mMie = 0;
    else if (mieSet) mMie = 1;
    else if (mieClr) mMie = 0;
    if (cntLoad) mCnt = mCh;
    else if (cntTick) mCnt = (mCnt == 0) ? mCh : mCnt - 8'd1;
    if (chWrite) mCh = chData;
    if (under) mCil = 1;
    else if (cilClear) mCil = 0;
    if (qWrite) mQ = qValue;
    else if (under && qFromCnt) mQ = ~mQ;
    mState = nxt;
    @(negedge clk);
  endtask

  task automatic idleInputs();
    execDone = 0; dmaInReq = 0; dmaOutReq = 0; extIntReq = 0; mieSet = 0;
    mieClr = 0; r0Load = 0; chWrite = 0; cntLoad = 0; cntTick = 0;
    cilClear = 0; qWrite = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #23 rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12 reset stealCycle", 32'(stealCycle), 0);
    check("R12 reset intAck", 32'(intAck), 0);
    check("R12 reset mie/cil/q", 32'({mie, cil, q}), 0);
    check("R12 reset cnt/tReg", 32'({cnt, tReg}), 0);
    check("R12 reset memAddr", 32'(memAddr), 0);

    // R11: DMA and enabled interrupt at the same execDone
    mieSet = 1; extIntEn = 1; curX = 4'hA; curP = 4'h5; cycle();
    idleInputs(); extIntReq = 1; dmaOutReq = 1; execDone = 1; memRdData = 8'h3C; cycle();
    check("R11 steal before interrupt", 32'({stealCycle, intAck}), 32'b10);
    execDone = 0; dmaOutReq = 0; cycle();
    execDone = 1; cycle();
    check("R11 interrupt entered afterwards", 32'(intAck), 1);
    check("R5 packed designators", 32'(tReg), 32'h A5);
    idleInputs(); cycle();

    // R4: R0 wraps on DMA-in, both requests present (R2 priority)
    r0Load = 1; r0LoadVal = 16'hFFFF; cycle();
    r0Load = 0; execDone = 1; dmaInReq = 1; dmaOutReq = 1; dmaInData = 8'h77; cycle();
    check("R2 in wins over out", 32'({memWrite, dmaOutValid}), 32'b10);
    idleInputs(); cycle();
    check("R4 wrap to zero", 32'(memAddr), 0);

    // R8: underflow and clear in the same cycle
    chWrite = 1; chData = 8'h02; cycle();
    idleInputs(); cntLoad = 1; cycle();
    idleInputs(); cntTick = 1; cycle(); cycle();
    cilClear = 1; qFromCnt = 1; cycle();
    idleInputs();
    check("R8 set beats clear", 32'(cil), 1);
    cilClear = 1; cycle(); idleInputs(); cycle();
    check("R8 clear releases latch", 32'(cil), 0);

    // R6: masked interrupt is ignored
    mieClr = 1; cycle(); idleInputs();
    extIntReq = 1; execDone = 1; cycle(); idleInputs(); cycle();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      execDone  = (mState == 0) && ($urandom % 2 == 0);
      dmaInReq  = ($urandom % 4 == 0);
      dmaOutReq = ($urandom % 4 == 0);
      dmaInData = 8'($urandom); memRdData = 8'($urandom);
      extIntReq = ($urandom % 2 == 0);
      extIntEn  = ($urandom % 4 != 0);
      cntIntEn  = ($urandom % 4 != 0);
      mieSet    = ($urandom % 4 == 0);
      mieClr    = ($urandom % 16 == 0);
      curX = 4'($urandom); curP = 4'($urandom);
      r0Load    = ($urandom % 32 == 0); r0LoadVal = 16'($urandom);
      chWrite   = ($urandom % 16 == 0); chData = 8'($urandom % 6);
      cntLoad   = ($urandom % 16 == 0);
      cntTick   = ($urandom % 2 == 0);
      cilClear  = ($urandom % 8 == 0);
      qWrite    = ($urandom % 16 == 0); qValue = 1'($urandom);
      qFromCnt  = 1'($urandom);
      cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule